// File: doc/BRIEF.md
# Slice-Addressed Register File

This block is a small register file for a datapath that moves data one narrow slice at a time. It holds sixteen 32-bit words. Each word is split into four 8-bit slices, and a single slice selector picks the same slice position for the one write port and for both read ports. A write replaces exactly one slice of one word. Each read port returns one slice of its own addressed word in the same cycle, with no register in the read path.

Word 0 is a hardwired zero. Writes aimed at it are discarded, and reading it returns zero even at power-on, before any reset. There is no write-to-read forwarding: a read of the word being written in the same cycle returns the value from before the clock edge. A debug output presents the whole storage array as one flat vector, so that a checker can watch the array.

Word width, slice width, address width and the number of read ports are parameters.

Top module: `rfs_regfile`

## Requirements
- R1: The array holds 2^ADDR_W words of WORD_W bits (16 x 32 by default). `dbg_array` bits [n*WORD_W +: WORD_W] carry word n.
- R2: Slice k of a word is bits [(k+1)*SLICE_W-1 : k*SLICE_W]. `slice_sel` = k selects slice k for the write port and for every read port.
- R3: Read port i (`rd_addr[i*ADDR_W +: ADDR_W]`, `rd_data[i*SLICE_W +: SLICE_W]`) shows the selected slice of its addressed word combinationally, in the same cycle as its address, with zero cycles of latency.
- R4: On a rising edge with `rst_n` high and `wr_en` high, `wr_data` replaces only the selected slice of the word at `wr_addr`. Every other slice and every other word keeps its value.
- R5: On a rising edge with `wr_en` low, no stored bit changes, whatever `wr_addr`, `wr_data` and `slice_sel` carry.
- R6: A write to address 0 is dropped, and word 0 stays zero in `dbg_array`.
- R7: A read port whose address is 0 outputs zero at all times, including before the first reset and after write attempts to address 0.
- R8: Driving `rst_n` low clears every word without waiting for a clock edge, and the words stay zero while `rst_n` is held low. A write requested while `rst_n` is low is discarded.
- R9: When a read port and the write port address the same nonzero word in one cycle, the read returns the slice value held before that cycle's rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears the array |
| slice_sel | input | 2 | Slice index shared by all ports |
| rd_addr | input | 8 | Read addresses, port i at [i*4 +: 4] |
| rd_data | output | 16 | Read slices, port i at [i*8 +: 8] |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 8 | Write slice data |
| dbg_array | output | 512 | Whole array, word n at [n*32 +: 32] |

## Verification
A read and a write can fall in the same cycle, including on the same word and slice. The bench provokes this by driving equal nonzero read and write addresses together with write enable. It samples the read ports after the inputs settle but before the clock edge, and expects the reference model's value from before the write. After the edge it expects the debug array to show the new slice. Writes to word 0 combined with reads of word 0, and a reset asserted together with a write, are judged the same way against the model.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  // Bit offset of a slice within the flattened array.
  function automatic int unsigned rfs_bit_base(input int unsigned word_idx,
                                               input int unsigned slice_idx,
                                               input int unsigned word_w,
                                               input int unsigned slice_w);
    return word_idx * word_w + slice_idx * slice_w;
  endfunction

  // Width of a selector over n choices, never below one bit.
  function automatic int unsigned rfs_sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rfs_write_decode.sv
module rfs_write_decode #(
  parameter int ADDR_W     = 4,
  parameter int NUM_SLICES = 4,
  parameter int SEL_W      = 2,
  localparam int NUM_WORDS = 1 << ADDR_W,
  localparam int EN_W      = (NUM_WORDS - 1) * NUM_SLICES
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SEL_W-1:0]  slice_sel,
  output logic [EN_W-1:0]   slice_we
);

  // Enables exist only for words 1..NUM_WORDS-1; word 0 has no storage.
  for (genvar w = 1; w < NUM_WORDS; w++) begin : g_word
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      assign slice_we[(w - 1) * NUM_SLICES + s] =
        wr_en && (wr_addr == ADDR_W'(w)) && (slice_sel == SEL_W'(s));
    end
  end

endmodule

// File: rtl/rfs_word.sv
module rfs_word #(
  parameter int WORD_W     = 32,
  parameter int SLICE_W    = 8,
  localparam int NUM_SLICES = WORD_W / SLICE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SLICES-1:0] slice_we,
  input  logic [SLICE_W-1:0]    wr_data,
  output logic [WORD_W-1:0]     q
);

  logic [WORD_W-1:0] q_nxt;
  logic              q_ce;

  // Next state: only the enabled slice takes the write data.
  always_comb begin
    q_nxt = q;
    for (int s = 0; s < NUM_SLICES; s++) begin
      if (slice_we[s]) begin
        q_nxt[s * SLICE_W +: SLICE_W] = wr_data;
      end
    end
  end

  assign q_ce = |slice_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_ce) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/rfs_read_mux.sv
module rfs_read_mux #(
  parameter int WORD_W  = 32,
  parameter int SLICE_W = 8,
  parameter int ADDR_W  = 4,
  parameter int SEL_W   = 2,
  localparam int NUM_WORDS = 1 << ADDR_W,
  localparam int ARR_W     = NUM_WORDS * WORD_W
) (
  input  logic [ARR_W-1:0]   arr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SEL_W-1:0]   slice_sel,
  output logic [SLICE_W-1:0] data
);

  int unsigned base;

  always_comb begin
    base = rfs_pkg::rfs_bit_base(int'(addr), int'(slice_sel), WORD_W, SLICE_W);
    data = arr[base +: SLICE_W];
  end

endmodule

// File: rtl/rfs_regfile.sv
module rfs_regfile #(
  parameter int WORD_W   = 32,
  parameter int SLICE_W  = 8,
  parameter int ADDR_W   = 4,
  parameter int RD_PORTS = 2,
  localparam int NUM_WORDS  = 1 << ADDR_W,
  localparam int NUM_SLICES = WORD_W / SLICE_W,
  localparam int SEL_W      = rfs_pkg::rfs_sel_width(NUM_SLICES),
  localparam int ARR_W      = NUM_WORDS * WORD_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SEL_W-1:0]              slice_sel,
  input  logic [RD_PORTS*ADDR_W-1:0]    rd_addr,
  output logic [RD_PORTS*SLICE_W-1:0]   rd_data,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [SLICE_W-1:0]            wr_data,
  output logic [ARR_W-1:0]              dbg_array
);

  localparam int EN_W = (NUM_WORDS - 1) * NUM_SLICES;

  logic [EN_W-1:0] slice_we;

  rfs_write_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_SLICES(NUM_SLICES),
    .SEL_W     (SEL_W)
  ) u_dec (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .slice_sel(slice_sel),
    .slice_we (slice_we)
  );

  // Word 0 is a constant: no flops, so it is zero from power-on.
  assign dbg_array[WORD_W-1:0] = '0;

  for (genvar w = 1; w < NUM_WORDS; w++) begin : g_store
    rfs_word #(
      .WORD_W (WORD_W),
      .SLICE_W(SLICE_W)
    ) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .slice_we(slice_we[(w - 1) * NUM_SLICES +: NUM_SLICES]),
      .wr_data (wr_data),
      .q       (dbg_array[w * WORD_W +: WORD_W])
    );
  end

  // Reads come straight off the storage: no forwarding of wr_data.
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    rfs_read_mux #(
      .WORD_W (WORD_W),
      .SLICE_W(SLICE_W),
      .ADDR_W (ADDR_W),
      .SEL_W  (SEL_W)
    ) u_mux (
      .arr      (dbg_array),
      .addr     (rd_addr[p * ADDR_W +: ADDR_W]),
      .slice_sel(slice_sel),
      .data     (rd_data[p * SLICE_W +: SLICE_W])
    );
  end

endmodule

// File: rtl/rfs_regfile_chk.sv
module rfs_regfile_chk #(
  parameter int WORD_W   = 32,
  parameter int SLICE_W  = 8,
  parameter int ADDR_W   = 4,
  parameter int RD_PORTS = 2,
  localparam int NUM_WORDS  = 1 << ADDR_W,
  localparam int NUM_SLICES = WORD_W / SLICE_W,
  localparam int SEL_W      = rfs_pkg::rfs_sel_width(NUM_SLICES),
  localparam int ARR_W      = NUM_WORDS * WORD_W
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [SEL_W-1:0]            slice_sel,
  input logic [RD_PORTS*ADDR_W-1:0]  rd_addr,
  input logic [RD_PORTS*SLICE_W-1:0] rd_data,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           wr_addr,
  input logic [SLICE_W-1:0]          wr_data,
  input logic [ARR_W-1:0]            dbg_array
);

  logic               exp_vld;
  int unsigned        exp_bit;
  logic [SLICE_W-1:0] exp_dat;
  logic               rst_seen_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_vld <= 1'b0;
      exp_bit <= 0;
      exp_dat <= '0;
    end else begin
      exp_vld <= wr_en && (wr_addr != '0);
      exp_bit <= rfs_pkg::rfs_bit_base(int'(wr_addr), int'(slice_sel), WORD_W, SLICE_W);
      exp_dat <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    rst_seen_low <= !rst_n;
  end

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exp_vld |-> (dbg_array[exp_bit +: SLICE_W] == exp_dat));

  p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dbg_array));

  p_word0_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_array[WORD_W-1:0] == '0);

  p_reset_clears_r8: assert property (@(posedge clk) disable iff (1'b0)
    (rst_seen_low === 1'b1) |-> (dbg_array == '0));

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
    p_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr[p * ADDR_W +: ADDR_W] == '0) |-> (rd_data[p * SLICE_W +: SLICE_W] == '0));

    p_read_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[p * SLICE_W +: SLICE_W] ==
        dbg_array[rfs_pkg::rfs_bit_base(int'(rd_addr[p * ADDR_W +: ADDR_W]),
                                        int'(slice_sel), WORD_W, SLICE_W) +: SLICE_W]);
  end

endmodule

bind rfs_regfile rfs_regfile_chk #(
  .WORD_W  (WORD_W),
  .SLICE_W (SLICE_W),
  .ADDR_W  (ADDR_W),
  .RD_PORTS(RD_PORTS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .slice_sel(slice_sel),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .dbg_array(dbg_array)
);

// File: tb/rfs_regfile_test.sv
module rfs_regfile_test;

  localparam int WW = 32;
  localparam int SW = 8;
  localparam int AW = 4;
  localparam int NP = 2;
  localparam int NW = 16;

  logic            clk;
  logic            rst_n;
  logic [1:0]      slice_sel;
  logic [NP*AW-1:0] rd_addr;
  logic [NP*SW-1:0] rd_data;
  logic            wr_en;
  logic [AW-1:0]   wr_addr;
  logic [SW-1:0]   wr_data;
  logic [NW*WW-1:0] dbg_array;

  int checks;
  int errors;

  logic [WW-1:0] mdl [NW];
  bit            mdl_valid;

  rfs_regfile uut (
    .clk(clk), .rst_n(rst_n), .slice_sel(slice_sel), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_array(dbg_array)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector: {rst_n, wr_en, wr_addr[3:0], slice_sel[1:0], wr_data[7:0], ra0[3:0], ra1[3:0]}
  localparam int NV = 20;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 1'b1, 4'd3,  2'd0, 8'hA5, 4'd3,  4'd0},
    {1'b1, 1'b1, 4'd3,  2'd1, 8'h5A, 4'd3,  4'd3},
    {1'b1, 1'b1, 4'd3,  2'd3, 8'hC3, 4'd0,  4'd3},
    {1'b1, 1'b0, 4'd3,  2'd1, 8'hFF, 4'd3,  4'd3},
    {1'b1, 1'b1, 4'd15, 2'd2, 8'h11, 4'd15, 4'd3},
    {1'b1, 1'b1, 4'd0,  2'd2, 8'hEE, 4'd0,  4'd15},
    {1'b1, 1'b1, 4'd15, 2'd2, 8'h22, 4'd15, 4'd15},
    {1'b1, 1'b1, 4'd7,  2'd0, 8'h01, 4'd7,  4'd7},
    {1'b1, 1'b1, 4'd7,  2'd0, 8'h02, 4'd7,  4'd1},
    {1'b1, 1'b1, 4'd1,  2'd3, 8'h80, 4'd7,  4'd1},
    {1'b1, 1'b0, 4'd1,  2'd3, 8'h00, 4'd1,  4'd7},
    {1'b1, 1'b1, 4'd1,  2'd0, 8'h7F, 4'd1,  4'd1},
    {1'b1, 1'b1, 4'd0,  2'd0, 8'h99, 4'd0,  4'd0},
    {1'b1, 1'b1, 4'd9,  2'd1, 8'h3C, 4'd9,  4'd15},
    {1'b1, 1'b0, 4'd9,  2'd1, 8'hAA, 4'd9,  4'd9},
    {1'b1, 1'b1, 4'd9,  2'd2, 8'h4B, 4'd3,  4'd9},
    {1'b0, 1'b1, 4'd9,  2'd2, 8'hDD, 4'd9,  4'd3},
    {1'b1, 1'b0, 4'd9,  2'd2, 8'h00, 4'd9,  4'd3},
    {1'b1, 1'b1, 4'd12, 2'd3, 8'h6D, 4'd12, 4'd0},
    {1'b1, 1'b0, 4'd12, 2'd3, 8'h00, 4'd12, 4'd12}
  };

  task automatic check(input string req, input logic [WW*NW-1:0] act,
                       input logic [WW*NW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NW*WW-1:0] mdl_flat();
    logic [NW*WW-1:0] f;
    for (int w = 0; w < NW; w++) f[w*WW +: WW] = mdl[w];
    return f;
  endfunction

  // One clock cycle: apply, check reads before the edge, update model, check array after.
  task automatic cycle(input logic [23:0] v, input string dbg_req);
    logic [AW-1:0] ra;
    logic [SW-1:0] exp;
    string         req;
    @(negedge clk);
    rst_n     = v[23];
    wr_en     = v[22];
    wr_addr   = v[21:18];
    slice_sel = v[17:16];
    wr_data   = v[15:8];
    rd_addr   = {v[3:0], v[7:4]};
    if (!rst_n) begin
      for (int w = 0; w < NW; w++) mdl[w] = '0;
      mdl_valid = 1'b1;
    end
    #1;
    for (int p = 0; p < NP; p++) begin
      ra = rd_addr[p*AW +: AW];
      if (ra == 0 || mdl_valid) begin
        exp = (ra == 0) ? '0 : mdl[ra][slice_sel*SW +: SW];
        if (ra == 0) req = "R7";
        else if (wr_en && rst_n && ra == wr_addr) req = "R9";
        else req = "R3";
        check(req, {{(NW*WW-SW){1'b0}}, rd_data[p*SW +: SW]}, {{(NW*WW-SW){1'b0}}, exp});
      end
    end
    @(posedge clk);
    if (rst_n && wr_en && wr_addr != 0 && mdl_valid)
      mdl[wr_addr][slice_sel*SW +: SW] = wr_data;
    #1;
    if (mdl_valid) check(dbg_req, dbg_array, mdl_flat());
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [WW-1:0] snap;
    checks = 0;
    errors = 0;
    mdl_valid = 1'b0;
    rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; slice_sel = '0; wr_data = '0; rd_addr = '0;

    // R7: power-on, no reset yet, word 0 read and write attempts on word 0.
    #2;
    check("R7", {{(NW*WW-NP*SW){1'b0}}, rd_data}, '0);
    cycle({1'b1, 1'b1, 4'd0, 2'd1, 8'hFF, 4'd0, 4'd0}, "R6");
    check("R7", {{(NW*WW-NP*SW){1'b0}}, rd_data}, '0);

    // R8: reset with a write pending.
    cycle({1'b0, 1'b1, 4'd5, 2'd0, 8'h77, 4'd5, 4'd0}, "R8");
    check("R8", dbg_array, '0);

    // R1: debug array width is the whole array.
    check("R1", ($bits(dbg_array) == NW*WW) ? 512'd1 : 512'd0, 512'd1);

    // Table walk.
    for (int i = 0; i < NV; i++) cycle(VEC[i], "R4");

    // R2: fill every slice of word 5 and check the byte layout.
    cycle({1'b1, 1'b1, 4'd5, 2'd0, 8'h10, 4'd5, 4'd0}, "R4");
    cycle({1'b1, 1'b1, 4'd5, 2'd1, 8'h32, 4'd5, 4'd0}, "R4");
    cycle({1'b1, 1'b1, 4'd5, 2'd2, 8'h54, 4'd5, 4'd0}, "R4");
    cycle({1'b1, 1'b1, 4'd5, 2'd3, 8'h76, 4'd5, 4'd0}, "R4");
    check("R2", {{(NW*WW-WW){1'b0}}, dbg_array[5*WW +: WW]}, {{(NW*WW-WW){1'b0}}, 32'h76543210});
    for (int s = 0; s < 4; s++) begin
      cycle({1'b1, 1'b0, 4'd0, s[1:0], 8'h00, 4'd5, 4'd5}, "R5");
      check("R2", {{(NW*WW-SW){1'b0}}, rd_data[SW-1:0]},
            {{(NW*WW-SW){1'b0}}, 8'(8'h10 + 8'(s * 8'h22))});
    end

    // R5: wr_en low with busy data lines.
    snap = dbg_array[5*WW +: WW];
    cycle({1'b1, 1'b0, 4'd5, 2'd2, 8'hEE, 4'd5, 4'd0}, "R5");
    check("R5", {{(NW*WW-WW){1'b0}}, dbg_array[5*WW +: WW]}, {{(NW*WW-WW){1'b0}}, snap});

    // R6: every slice of word 0.
    for (int s = 0; s < 4; s++) cycle({1'b1, 1'b1, 4'd0, s[1:0], 8'hAB, 4'd0, 4'd0}, "R6");
    check("R6", {{(NW*WW-WW){1'b0}}, dbg_array[WW-1:0]}, '0);

    // R9: collision on both ports.
    cycle({1'b1, 1'b1, 4'd5, 2'd3, 8'h0F, 4'd5, 4'd5}, "R4");
    check("R9", {{(NW*WW-SW){1'b0}}, rd_data[SW-1:0]}, {{(NW*WW-SW){1'b0}}, 8'h0F});

    // R8: reset again clears everything.
    cycle({1'b0, 1'b0, 4'd0, 2'd0, 8'h00, 4'd5, 4'd15}, "R8");
    check("R8", dbg_array, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule